// File: doc/BRIEF.md
# Wide System Timer with Alarm Comparator

This block is a free-running 52-bit tick counter with one alarm comparator and a one-bit interrupt. All control goes through a small 32-bit register port. Software can preload the counter and take a coherent snapshot of it. It can also program either an absolute alarm point or a repeating interval, and it receives a sticky interrupt.

The counter runs only while both the global clock gate and the counter run bit are set. A read of the counter is a handshake: software writes an update request, waits for the valid flag, and then reads two value words that no longer move. Comparator settings are staged. The target words and the mode/interval register have no effect until software writes the comparator commit strobe. The interrupt has four views: a raw latch, an enable mask, a write-1-to-clear port, and the masked status that also drives the `irq` pin.

Register reads take one cycle: `bus_rdata` shows, after each clock edge, the register selected by `bus_addr` before that edge. Writes take effect on the edge where `bus_wr` is high.

Top module: `stmr_top`

## Requirements
- R1: After synchronous reset, every register reads 0, the counter is 0 and `irq` is 0.
- R2: Config register 0x00 holds a clock gate at bit 31, a counter run bit at bit 30 and a comparator enable at bit 24. The counter grows by exactly one per clock only while bits 31 and 30 are both 1. Otherwise it holds its value.
- R3: Software writes load words 0x0C (high, bits [19:0]) and 0x10 (low, 32 bits), then writes bit 0 = 1 to 0x5C. The counter takes the 52-bit load value on that edge and keeps counting from it.
- R4: A write to 0x04 with bit 30 = 1 copies the counter into 0x40 (bits [51:32]) and 0x44 (bits [31:0]). In the cycle after that write, bit 29 of 0x04 reads 0. From the following cycle it reads 1. The value words hold their contents until the next update request.
- R5: Target words 0x1C (high 20 bits) and 0x20 (low 32 bits) and register 0x34 (interval in [25:0], repeat mode at bit 30, unit select at bit 31) change nothing in the alarm until bit 0 = 1 is written to 0x50.
- R6: When 0x34 bit 30 was 0 at commit, the alarm raises raw interrupt bit 0 once the comparator is enabled and the counter is at or above the committed target. It then does not fire again until the next commit.
- R7: When 0x34 bit 30 was 1 at commit, the first alarm point is the counter value at the commit edge plus the interval. Each firing moves the alarm point forward by the interval.
- R8: 0x68 bit 0 is the raw interrupt (read-only). 0x64 bit 0 is the enable. 0x70 bit 0 is raw AND enable. `irq` equals 0x70 bit 0.
- R9: Writing bit 0 = 1 to 0x6C clears the raw interrupt. If the alarm fires in the same cycle as that write, the raw interrupt stays set.
- R10: The strobe locations 0x50, 0x5C and 0x6C, and bit 30 of 0x04, always read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| irq | output | 1 | Masked alarm interrupt |

## Verification
The bench builds the block with its default widths: a 52-bit counter and a 26-bit interval. With these widths, a preload whose high word is nonzero exercises the split between the 20-bit and 32-bit halves. The short intervals and the targets near zero bring one-shot, repeating, masked and clear-collision cases within a few hundred cycles. A behavioural model in the bench predicts `bus_rdata` and `irq` on every clock. Directed checks time the first and second repeat alarms to the exact cycle, and they force an alarm to coincide with a clear write.

// File: rtl/stmr_pkg.sv
package stmr_pkg;
  // Register byte offsets; software decodes these.
  localparam int OFS_CFG    = 'h00;
  localparam int OFS_OP     = 'h04;
  localparam int OFS_LDHI   = 'h0C;
  localparam int OFS_LDLO   = 'h10;
  localparam int OFS_TGHI   = 'h1C;
  localparam int OFS_TGLO   = 'h20;
  localparam int OFS_TCONF  = 'h34;
  localparam int OFS_VALHI  = 'h40;
  localparam int OFS_VALLO  = 'h44;
  localparam int OFS_CMPLD  = 'h50;
  localparam int OFS_UNITLD = 'h5C;
  localparam int OFS_IENA   = 'h64;
  localparam int OFS_IRAW   = 'h68;
  localparam int OFS_ICLR   = 'h6C;
  localparam int OFS_IST    = 'h70;

  // Bit positions
  localparam int B_CLKON  = 31;
  localparam int B_RUNON  = 30;
  localparam int B_CMPON  = 24;
  localparam int B_UPD    = 30;
  localparam int B_VALID  = 29;
  localparam int B_REPEAT = 30;
  localparam int B_USEL   = 31;
endpackage

// File: rtl/stmr_unit.sv
module stmr_unit #(
  parameter int CNT_W = 52
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             ld_stb,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             upd_stb,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] snap,
  output logic             valid
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      snap  <= '0;
      valid <= 1'b0;
      pend  <= 1'b0;
    end else begin
      if (ld_stb)   cnt <= ld_val;
      else if (run) cnt <= cnt + CNT_W'(1);
      pend <= upd_stb;
      if (upd_stb) begin
        snap  <= cnt;
        valid <= 1'b0;
      end else if (pend) begin
        valid <= 1'b1;
      end
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !ld_stb) |=> cnt == $past(cnt));
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (run && !ld_stb) |=> cnt == $past(cnt) + CNT_W'(1));
  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    ld_stb |=> cnt == $past(ld_val));
  a_r4_drop: assert property (@(posedge clk) disable iff (rst)
    upd_stb |=> !valid);
  a_r4_ready: assert property (@(posedge clk) disable iff (rst)
    (upd_stb ##1 !upd_stb) |=> valid);
endmodule

// File: rtl/stmr_cmp.sv
module stmr_cmp #(
  parameter int CNT_W = 52,
  parameter int PER_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cmp_en,
  input  logic             ld_stb,
  input  logic [CNT_W-1:0] tgt,
  input  logic [PER_W-1:0] per,
  input  logic             rep,
  output logic             hit
);
  logic             armed;
  logic             rep_a;
  logic [PER_W-1:0] per_a;
  logic [CNT_W-1:0] nxt;

  assign hit = cmp_en && armed && (cnt >= nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      rep_a <= 1'b0;
      per_a <= '0;
      nxt   <= '0;
    end else if (ld_stb) begin
      armed <= 1'b1;
      rep_a <= rep;
      per_a <= per;
      nxt   <= rep ? cnt + CNT_W'(per) : tgt;
    end else if (hit) begin
      if (rep_a) nxt <= nxt + CNT_W'(per_a);
      else       armed <= 1'b0;
    end
  end

  a_r6_single: assert property (@(posedge clk) disable iff (rst)
    (hit && !rep_a && !ld_stb) |=> !hit);
  a_r5_staged: assert property (@(posedge clk) disable iff (rst)
    !ld_stb |=> ($stable(rep_a) && $stable(per_a)));
  a_r7_rearm: assert property (@(posedge clk) disable iff (rst)
    (hit && rep_a) |=> armed);
endmodule

// File: rtl/stmr_top.sv
module stmr_top
  import stmr_pkg::*;
#(
  parameter int CNT_W = 52,
  parameter int PER_W = 26,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  localparam int HI_W = CNT_W - 32;

  logic            cfg_clk, cfg_run, cfg_cmp;
  logic [HI_W-1:0] ld_hi, tg_hi;
  logic [31:0]     ld_lo, tg_lo;
  logic [PER_W-1:0] per_q;
  logic            rep_q, usel_q, ena_q, raw_q;
  logic [CNT_W-1:0] cnt, snap;
  logic            valid, hit;
  logic [31:0]     rd_mux;

  function automatic logic sel(input logic [AW-1:0] a, input int ofs);
    return a == AW'(ofs);
  endfunction

  wire upd_stb = bus_wr && sel(bus_addr, OFS_OP)     && bus_wdata[B_UPD];
  wire uld_stb = bus_wr && sel(bus_addr, OFS_UNITLD) && bus_wdata[0];
  wire cld_stb = bus_wr && sel(bus_addr, OFS_CMPLD)  && bus_wdata[0];
  wire clr_stb = bus_wr && sel(bus_addr, OFS_ICLR)   && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_clk <= 1'b0; cfg_run <= 1'b0; cfg_cmp <= 1'b0;
      ld_hi <= '0; ld_lo <= '0; tg_hi <= '0; tg_lo <= '0;
      per_q <= '0; rep_q <= 1'b0; usel_q <= 1'b0; ena_q <= 1'b0;
    end else if (bus_wr) begin
      if (sel(bus_addr, OFS_CFG)) begin
        cfg_clk <= bus_wdata[B_CLKON];
        cfg_run <= bus_wdata[B_RUNON];
        cfg_cmp <= bus_wdata[B_CMPON];
      end
      if (sel(bus_addr, OFS_LDHI)) ld_hi <= bus_wdata[HI_W-1:0];
      if (sel(bus_addr, OFS_LDLO)) ld_lo <= bus_wdata;
      if (sel(bus_addr, OFS_TGHI)) tg_hi <= bus_wdata[HI_W-1:0];
      if (sel(bus_addr, OFS_TGLO)) tg_lo <= bus_wdata;
      if (sel(bus_addr, OFS_TCONF)) begin
        per_q  <= bus_wdata[PER_W-1:0];
        rep_q  <= bus_wdata[B_REPEAT];
        usel_q <= bus_wdata[B_USEL];
      end
      if (sel(bus_addr, OFS_IENA)) ena_q <= bus_wdata[0];
    end
  end

  // Sticky raw latch: an alarm in the clear cycle wins.
  always_ff @(posedge clk) begin
    if (rst) raw_q <= 1'b0;
    else     raw_q <= hit || (raw_q && !clr_stb);
  end

  assign irq = raw_q && ena_q;

  stmr_unit #(.CNT_W(CNT_W)) u_unit (
    .clk(clk), .rst(rst), .run(cfg_clk && cfg_run), .ld_stb(uld_stb),
    .ld_val({ld_hi, ld_lo}), .upd_stb(upd_stb),
    .cnt(cnt), .snap(snap), .valid(valid)
  );

  stmr_cmp #(.CNT_W(CNT_W), .PER_W(PER_W)) u_cmp (
    .clk(clk), .rst(rst), .cnt(cnt), .cmp_en(cfg_cmp), .ld_stb(cld_stb),
    .tgt({tg_hi, tg_lo}), .per(per_q), .rep(rep_q), .hit(hit)
  );

  always_comb begin
    rd_mux = '0;
    if (sel(bus_addr, OFS_CFG)) begin
      rd_mux[B_CLKON] = cfg_clk;
      rd_mux[B_RUNON] = cfg_run;
      rd_mux[B_CMPON] = cfg_cmp;
    end
    if (sel(bus_addr, OFS_OP))    rd_mux[B_VALID] = valid;
    if (sel(bus_addr, OFS_LDHI))  rd_mux[HI_W-1:0] = ld_hi;
    if (sel(bus_addr, OFS_LDLO))  rd_mux = ld_lo;
    if (sel(bus_addr, OFS_TGHI))  rd_mux[HI_W-1:0] = tg_hi;
    if (sel(bus_addr, OFS_TGLO))  rd_mux = tg_lo;
    if (sel(bus_addr, OFS_TCONF)) begin
      rd_mux[PER_W-1:0] = per_q;
      rd_mux[B_REPEAT]  = rep_q;
      rd_mux[B_USEL]    = usel_q;
    end
    if (sel(bus_addr, OFS_VALHI)) rd_mux[HI_W-1:0] = snap[CNT_W-1:32];
    if (sel(bus_addr, OFS_VALLO)) rd_mux = snap[31:0];
    if (sel(bus_addr, OFS_IENA))  rd_mux[0] = ena_q;
    if (sel(bus_addr, OFS_IRAW))  rd_mux[0] = raw_q;
    if (sel(bus_addr, OFS_IST))   rd_mux[0] = raw_q && ena_q;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  a_r9_no_loss: assert property (@(posedge clk) disable iff (rst)
    hit |=> raw_q);
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_stb && !hit) |=> !raw_q);
  a_r8_masked: assert property (@(posedge clk) disable iff (rst)
    !ena_q |-> !irq);
  a_r10_strobe_rd: assert property (@(posedge clk) disable iff (rst)
    (sel(bus_addr, OFS_CMPLD) || sel(bus_addr, OFS_ICLR)) |=> bus_rdata == 32'd0);
endmodule

// File: tb/stmr_top_tb_top.sv
module stmr_top_tb_top;
  localparam longint MASK = (64'd1 << 52) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit chk_on = 1'b0;
  string irq_tag = "R8";

  always #2 clk = ~clk;

  stmr_top dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Behavioural reference state
  bit     m_clk, m_run, m_cen, m_valid, m_pend, m_armed, m_rep, m_rep_a, m_usel, m_ena, m_raw;
  longint m_ldhi, m_ldlo, m_tghi, m_tglo, m_per, m_per_a, m_cnt, m_snap, m_next;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return {m_clk, m_run, 5'd0, m_cen, 24'd0};
      8'h04: return {2'b0, m_valid, 29'd0};
      8'h0C: return 32'(m_ldhi);
      8'h10: return 32'(m_ldlo);
      8'h1C: return 32'(m_tghi);
      8'h20: return 32'(m_tglo);
      8'h34: return {m_usel, m_rep, 4'd0, 26'(m_per)};
      8'h40: return 32'(m_snap >> 32);
      8'h44: return 32'(m_snap);
      8'h64: return {31'd0, m_ena};
      8'h68: return {31'd0, m_raw};
      8'h70: return {31'd0, m_raw & m_ena};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h04, 8'h40, 8'h44: return "R2,R4";
      8'h0C, 8'h10: return "R3";
      8'h1C, 8'h20, 8'h34: return "R5";
      8'h50, 8'h5C, 8'h6C: return "R10";
      8'h64, 8'h68, 8'h70: return "R8";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_clk = 0; m_run = 0; m_cen = 0; m_valid = 0; m_pend = 0; m_armed = 0;
      m_rep = 0; m_rep_a = 0; m_usel = 0; m_ena = 0; m_raw = 0;
      m_ldhi = 0; m_ldlo = 0; m_tghi = 0; m_tglo = 0; m_per = 0; m_per_a = 0;
      m_cnt = 0; m_snap = 0; m_next = 0; m_rdata = 0;
    end else begin
      bit hit_now;
      bit w0;
      longint cnt_new;
      w0 = bus_wr;
      m_rdata = m_read(bus_addr);
      hit_now = m_cen && m_armed && (m_cnt >= m_next);
      cnt_new = m_cnt;
      if (w0 && bus_addr == 8'h5C && bus_wdata[0]) cnt_new = (m_ldhi << 32) | m_ldlo;
      else if (m_clk && m_run) cnt_new = (m_cnt + 1) & MASK;
      if (w0 && bus_addr == 8'h04 && bus_wdata[30]) begin
        m_snap = m_cnt; m_valid = 0; m_pend = 1;
      end else begin
        if (m_pend) m_valid = 1;
        m_pend = 0;
      end
      if (w0 && bus_addr == 8'h50 && bus_wdata[0]) begin
        m_armed = 1; m_rep_a = m_rep; m_per_a = m_per;
        m_next = m_rep ? ((m_cnt + m_per) & MASK) : ((m_tghi << 32) | m_tglo);
      end else if (hit_now) begin
        if (m_rep_a) m_next = (m_next + m_per_a) & MASK;
        else m_armed = 0;
      end
      m_raw = hit_now || (m_raw && !(w0 && bus_addr == 8'h6C && bus_wdata[0]));
      if (w0) begin
        case (bus_addr)
          8'h00: begin m_clk = bus_wdata[31]; m_run = bus_wdata[30]; m_cen = bus_wdata[24]; end
          8'h0C: m_ldhi = longint'(bus_wdata[19:0]);
          8'h10: m_ldlo = longint'(bus_wdata);
          8'h1C: m_tghi = longint'(bus_wdata[19:0]);
          8'h20: m_tglo = longint'(bus_wdata);
          8'h34: begin m_per = longint'(bus_wdata[25:0]); m_rep = bus_wdata[30]; m_usel = bus_wdata[31]; end
          8'h64: m_ena = bus_wdata[0];
          default: ;
        endcase
      end
      m_cnt = cnt_new;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Compare against the model on every clock
  always @(negedge clk) begin
    if (chk_on && !rst) begin
      check(tag_of(bus_addr), longint'(bus_rdata), longint'(m_rdata));
      check(irq_tag, longint'(irq), longint'(m_raw & m_ena));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] v, a0, b0;
    int k;
    logic [7:0] addrs [15] = '{8'h00, 8'h04, 8'h0C, 8'h10, 8'h1C, 8'h20, 8'h34, 8'h40,
                               8'h44, 8'h50, 8'h5C, 8'h64, 8'h68, 8'h6C, 8'h70};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk_on = 1'b1;
    // R1: reset state
    check("R1 irq", longint'(irq), 0);
    for (int i = 0; i < 15; i++) begin
      rd(addrs[i], v);
      check("R1", longint'(v), 0);
    end

    // R3 / R4: preload with counter stopped, then snapshot
    wr(8'h0C, 32'h000ABCDE);
    wr(8'h10, 32'h12345678);
    wr(8'h5C, 32'h1);
    wr(8'h04, 32'h4000_0000);
    rd(8'h04, v); check("R4 valid low", longint'(v), 0);
    rd(8'h04, v); check("R4 valid high", longint'(v), 32'h2000_0000);
    rd(8'h40, v); check("R3 high word", longint'(v), 32'h000ABCDE);
    rd(8'h44, v); check("R3 low word", longint'(v), 32'h12345678);
    // R10: strobes read as zero
    rd(8'h5C, v); check("R10 unit load", longint'(v), 0);
    rd(8'h50, v); check("R10 cmp load", longint'(v), 0);
    rd(8'h6C, v); check("R10 clear", longint'(v), 0);

    // R2: run bit alone does not count
    wr(8'h00, 32'h4000_0000);
    idle(5);
    wr(8'h04, 32'h4000_0000);
    idle(1);
    rd(8'h44, v); check("R2 hold", longint'(v), 32'h12345678);
    // R2: both bits set, exact step count between snapshots
    wr(8'h00, 32'hC000_0000);
    wr(8'h04, 32'h4000_0000);
    rd(8'h44, a0);
    idle(7);
    wr(8'h04, 32'h4000_0000);
    idle(1);
    rd(8'h44, b0);
    check("R2 step", longint'(b0 - a0), 9);

    // R6: one-shot alarm
    irq_tag = "R6";
    wr(8'h0C, 32'h0); wr(8'h10, 32'h0); wr(8'h5C, 32'h1);
    wr(8'h64, 32'h1);
    wr(8'h1C, 32'h0); wr(8'h20, 32'd40);
    wr(8'h34, 32'h0);
    wr(8'h50, 32'h1);
    wr(8'h00, 32'hC100_0000);
    idle(80);
    rd(8'h68, v); check("R6 fired", longint'(v), 1);
    wr(8'h6C, 32'h1);
    idle(60);
    rd(8'h68, v); check("R6 once only", longint'(v), 0);

    // R5: staged target has no effect until commit
    irq_tag = "R5";
    wr(8'h20, 32'd5);
    idle(10);
    rd(8'h68, v); check("R5 uncommitted", longint'(v), 0);
    wr(8'h50, 32'h1);
    idle(3);
    rd(8'h68, v); check("R5 committed", longint'(v), 1);
    wr(8'h6C, 32'h1);

    // R7: repeating alarm, first and second interval
    irq_tag = "R7";
    wr(8'h34, 32'h4000_000D);
    wr(8'h6C, 32'h1);
    wr(8'h50, 32'h1);
    k = 0;
    while (!irq && k < 100) begin @(negedge clk); k++; end
    check("R7 first period", k, 13);
    wr(8'h6C, 32'h1);
    k = 0;
    while (!irq && k < 100) begin @(negedge clk); k++; end
    check("R7 second period", k, 12);

    // R9: alarm coinciding with a clear write
    irq_tag = "R9";
    wr(8'h00, 32'hC000_0000);
    wr(8'h34, 32'h0);
    wr(8'h1C, 32'h0); wr(8'h20, 32'h0);
    wr(8'h50, 32'h1);
    wr(8'h6C, 32'h1);
    wr(8'h00, 32'hC100_0000);
    wr(8'h6C, 32'h1);
    rd(8'h68, v); check("R9 kept", longint'(v), 1);
    check("R9 irq", longint'(irq), 1);
    wr(8'h6C, 32'h1);
    rd(8'h68, v); check("R9 cleared", longint'(v), 0);

    // R8: masked interrupt
    irq_tag = "R8";
    wr(8'h64, 32'h0);
    wr(8'h50, 32'h1);
    idle(3);
    rd(8'h68, v); check("R8 raw", longint'(v), 1);
    rd(8'h70, v); check("R8 status", longint'(v), 0);
    check("R8 irq", longint'(irq), 0);
    wr(8'h64, 32'h1);
    rd(8'h70, v); check("R8 status on", longint'(v), 1);
    check("R8 irq on", longint'(irq), 1);

    idle(4);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule